// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block translates a 48-bit virtual address into a 52-bit physical address by walking a four-level radix tree of 64-bit table entries stored in memory. A requester offers a virtual address, an access kind (read, write or instruction fetch) and a privilege flag. The block then fetches one entry per level through a single request/response memory port. It checks presence and permissions, and it finishes with either a physical address or a fault that carries a three-bit cause.

The root table's frame number comes from a base input, which software reloads whenever the address space changes. A third-level entry can map a 2 MB region directly, which ends the walk after three reads. When a walk succeeds, the block writes the final entry back with its accessed bit set. On a write it also sets the dirty bit. This write-back happens only when one of those bits was still clear.

Top module: `pt_walker`

## Requirements
- R1: After reset, and while no walk is in progress, `req_ready` is 1, `mem_req_valid` is 0, and `done` and `fault` are 0. A reset during a walk abandons the walk and returns the block to this idle state.
- R2: The root table frame is `base_pfn`. The level indices are virtual-address bits 47:39, 38:30, 29:21 and 20:12, taken in that order. Each entry is read at byte address `{table_frame, 12'b0} + index*8`.
- R3: A walk ends at the fourth-level entry unless R4 applies. The physical address is then entry bits 51:12 followed by virtual-address bits 11:0.
- R4: A present third-level entry with bit 7 set maps a 2 MB page. The walk stops after three reads, and the physical address is entry bits 51:21 followed by virtual-address bits 20:0.
- R5: An entry with bit 0 clear, at any level, ends the walk with a fault whose protection flag is 0. No further read and no write-back follow.
- R6: Access kind encoding is 0 = read, 1 = write, 2 = fetch. A write faults unless bit 1 is set in every entry of the walk. A fetch faults if bit 63 is set in any entry of the walk. Bit 63 has no effect on reads or writes.
- R7: A user access (`req_user` = 1) faults unless bit 2 is set in every entry of the walk. Supervisor accesses ignore bit 2.
- R8: `fault_cause` is {protection, write, user}. Bit 2 is 1 for a permission fault and 0 for a not-present fault. Bit 1 is 1 when the access kind was write. Bit 0 is the request's user flag.
- R9: After all checks pass, the final entry is written back to its own address when its bit 5 (accessed) is clear, or when the access is a write and its bit 6 (dirty) is clear. The written value has bit 5 set and has bit 6 set only for writes. The other bits are unchanged. `done` follows the accepted write.
- R10: When no write-back is needed, no memory write is issued and `done` follows the last read response.
- R11: Each accepted request produces exactly one single-cycle pulse, on either `done` or `fault`, never both. `req_ready` stays 0 from acceptance until after that pulse.
- R12: A memory request holds its valid, address, write flag and write data unchanged until `mem_req_ready` accepts it. Reads and write-backs are 8-byte aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Block idle and accepting a request |
| req_vaddr | input | 48 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_user | input | 1 | 1 for a user-mode access |
| base_pfn | input | 40 | Frame number of the root table |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_write | output | 1 | 1 for an entry write-back, 0 for a read |
| mem_req_addr | output | 52 | Byte address of the entry |
| mem_req_wdata | output | 64 | Entry value for a write-back |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry value returned by a read |
| done | output | 1 | Pulse: translation succeeded |
| paddr | output | 52 | Physical address, valid with done |
| fault | output | 1 | Pulse: translation failed |
| fault_cause | output | 3 | {protection, write, user}, valid with fault |

## Verification
Two functions can coincide in the final step of a walk. The permission verdict and the accessed/dirty write-back decision are both taken on the same last read response, and a single flaw could let a failing access still update its entry. The bench provokes this with leaves whose A or D bits are clear and which fail a write, fetch or user check. It expects a fault with zero memory writes. It then repeats the same leaves with a legal access, where it expects exactly one write with the required A/D bits. Every vector is applied twice: once with an always-ready memory and once with a memory that refuses every other cycle, so that results must not depend on when requests are accepted.

// File: rtl/pw_pkg.sv
package pw_pkg;
  // Access kinds
  localparam logic [1:0] ACC_RD = 2'd0;
  localparam logic [1:0] ACC_WR = 2'd1;
  localparam logic [1:0] ACC_FX = 2'd2;

  // Entry bit positions
  localparam int BIT_P  = 0;
  localparam int BIT_W  = 1;
  localparam int BIT_U  = 2;
  localparam int BIT_A  = 5;
  localparam int BIT_D  = 6;
  localparam int BIT_PS = 7;
  localparam int BIT_NX = 63;

  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_WAIT, S_WB, S_DONE, S_FAULT
  } walk_st_e;

  typedef struct packed {
    logic prot;
    logic wr;
    logic usr;
  } cause_t;
endpackage

// File: rtl/pw_idx_sel.sv
module pw_idx_sel #(
  parameter int VA_W   = 48,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int LEVELS = 4,
  localparam int LVL_W = $clog2(LEVELS)
) (
  input  logic [VA_W-1:0]  vaddr,
  input  logic [LVL_W-1:0] level,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] idx_arr [LEVELS];

  // Level 0 uses the highest index field.
  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    assign idx_arr[g] = vaddr[OFF_W + IDX_W*(LEVELS-1-g) +: IDX_W];
  end

  assign idx = idx_arr[level];
endmodule

// File: rtl/pw_perm.sv
module pw_perm
  import pw_pkg::*;
(
  input  logic [1:0] acc,
  input  logic       user,
  input  logic       eff_w,
  input  logic       eff_u,
  input  logic       eff_nx,
  output logic       viol
);
  always_comb begin
    viol = 1'b0;
    if (acc == ACC_WR && !eff_w)  viol = 1'b1;
    if (acc == ACC_FX && eff_nx)  viol = 1'b1;
    if (user && !eff_u)           viol = 1'b1;
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pw_pkg::*;
#(
  parameter int VA_W     = 48,
  parameter int PA_W     = 52,
  parameter int IDX_W    = 9,
  parameter int OFF_W    = 12,
  parameter int LEVELS   = 4,
  parameter int LP_LEVEL = 2,
  parameter int ENT_W    = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_acc,
  input  logic              req_user,
  input  logic [PA_W-OFF_W-1:0] base_pfn,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [PA_W-1:0]   mem_req_addr,
  output logic [ENT_W-1:0]  mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [ENT_W-1:0]  mem_rsp_data,
  output logic              done,
  output logic [PA_W-1:0]   paddr,
  output logic              fault,
  output logic [2:0]        fault_cause
);
  localparam int FRAME_W = PA_W - OFF_W;
  localparam int LVL_W   = $clog2(LEVELS);
  localparam int LP_OFF  = OFF_W + IDX_W*(LEVELS-1-LP_LEVEL);
  localparam int ENT_SH  = $clog2(ENT_W/8);
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS-1);
  localparam logic [LVL_W-1:0] BIG_LVL  = LVL_W'(LP_LEVEL);

  walk_st_e            state_q, state_d;
  logic [LVL_W-1:0]    level_q, level_d;
  logic [VA_W-1:0]     va_q, va_d;
  logic [1:0]          acc_q, acc_d;
  logic                user_q, user_d;
  logic [FRAME_W-1:0]  table_q, table_d;
  logic [PA_W-1:0]     ent_addr_q, ent_addr_d;
  logic                eff_w_q, eff_w_d;
  logic                eff_u_q, eff_u_d;
  logic                eff_nx_q, eff_nx_d;
  logic [PA_W-1:0]     paddr_q, paddr_d;
  logic [ENT_W-1:0]    wdata_q, wdata_d;
  cause_t              cause_q, cause_d;

  logic [IDX_W-1:0]    idx;
  logic [PA_W-1:0]     entry_addr;
  logic [ENT_W-1:0]    rd;
  logic                w_n, u_n, nx_n, viol;
  logic                is_leaf, is_big, is_write, need_wb;
  logic [PA_W-1:0]     pa_leaf;
  logic [ENT_W-1:0]    wb_data;

  pw_idx_sel #(
    .VA_W(VA_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .LEVELS(LEVELS)
  ) u_idx (
    .vaddr(va_q), .level(level_q), .idx(idx)
  );

  assign entry_addr = {table_q, {OFF_W{1'b0}}}
                    | ({{(PA_W-IDX_W){1'b0}}, idx} << ENT_SH);

  // Cumulative permissions including the entry now arriving
  assign rd       = mem_rsp_data;
  assign w_n      = eff_w_q & rd[BIT_W];
  assign u_n      = eff_u_q & rd[BIT_U];
  assign nx_n     = eff_nx_q | rd[BIT_NX];
  assign is_write = (acc_q == ACC_WR);
  assign is_big   = (level_q == BIG_LVL) && rd[BIT_PS];
  assign is_leaf  = (level_q == LAST_LVL) || is_big;
  assign pa_leaf  = is_big ? {rd[PA_W-1:LP_OFF], va_q[LP_OFF-1:0]}
                           : {rd[PA_W-1:OFF_W], va_q[OFF_W-1:0]};
  assign need_wb  = !rd[BIT_A] || (is_write && !rd[BIT_D]);
  assign wb_data  = rd | (ENT_W'(1) << BIT_A)
                       | (is_write ? (ENT_W'(1) << BIT_D) : '0);

  pw_perm u_perm (
    .acc(acc_q), .user(user_q), .eff_w(w_n), .eff_u(u_n),
    .eff_nx(nx_n), .viol(viol)
  );

  // Next-state logic
  always_comb begin
    state_d    = state_q;
    level_d    = level_q;
    va_d       = va_q;
    acc_d      = acc_q;
    user_d     = user_q;
    table_d    = table_q;
    ent_addr_d = ent_addr_q;
    eff_w_d    = eff_w_q;
    eff_u_d    = eff_u_q;
    eff_nx_d   = eff_nx_q;
    paddr_d    = paddr_q;
    wdata_d    = wdata_q;
    cause_d    = cause_q;
    unique case (state_q)
      S_IDLE: if (req_valid) begin
        va_d     = req_vaddr;
        acc_d    = req_acc;
        user_d   = req_user;
        table_d  = base_pfn;
        level_d  = '0;
        eff_w_d  = 1'b1;
        eff_u_d  = 1'b1;
        eff_nx_d = 1'b0;
        state_d  = S_RD;
      end
      S_RD: if (mem_req_ready) begin
        ent_addr_d = entry_addr;
        state_d    = S_WAIT;
      end
      S_WAIT: if (mem_rsp_valid) begin
        if (!rd[BIT_P]) begin
          cause_d = '{prot: 1'b0, wr: is_write, usr: user_q};
          state_d = S_FAULT;
        end else begin
          eff_w_d  = w_n;
          eff_u_d  = u_n;
          eff_nx_d = nx_n;
          if (!is_leaf) begin
            table_d = rd[PA_W-1:OFF_W];
            level_d = level_q + 1'b1;
            state_d = S_RD;
          end else if (viol) begin
            cause_d = '{prot: 1'b1, wr: is_write, usr: user_q};
            state_d = S_FAULT;
          end else begin
            paddr_d = pa_leaf;
            wdata_d = wb_data;
            state_d = need_wb ? S_WB : S_DONE;
          end
        end
      end
      S_WB:    if (mem_req_ready) state_d = S_DONE;
      S_DONE:  state_d = S_IDLE;
      S_FAULT: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // State and data registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      level_q    <= '0;
      va_q       <= '0;
      acc_q      <= '0;
      user_q     <= 1'b0;
      table_q    <= '0;
      ent_addr_q <= '0;
      eff_w_q    <= 1'b0;
      eff_u_q    <= 1'b0;
      eff_nx_q   <= 1'b0;
      paddr_q    <= '0;
      wdata_q    <= '0;
      cause_q    <= '0;
    end else begin
      state_q    <= state_d;
      level_q    <= level_d;
      va_q       <= va_d;
      acc_q      <= acc_d;
      user_q     <= user_d;
      table_q    <= table_d;
      ent_addr_q <= ent_addr_d;
      eff_w_q    <= eff_w_d;
      eff_u_q    <= eff_u_d;
      eff_nx_q   <= eff_nx_d;
      paddr_q    <= paddr_d;
      wdata_q    <= wdata_d;
      cause_q    <= cause_d;
    end
  end

  assign req_ready     = (state_q == S_IDLE);
  assign mem_req_valid = (state_q == S_RD) || (state_q == S_WB);
  assign mem_req_write = (state_q == S_WB);
  assign mem_req_addr  = (state_q == S_WB) ? ent_addr_q : entry_addr;
  assign mem_req_wdata = wdata_q;
  assign done          = (state_q == S_DONE);
  assign fault         = (state_q == S_FAULT);
  assign paddr         = paddr_q;
  assign fault_cause   = cause_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int PA_W  = 52,
  parameter int ENT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic             mem_req_write,
  input logic [PA_W-1:0]  mem_req_addr,
  input logic [ENT_W-1:0] mem_req_wdata,
  input logic             done,
  input logic             fault
);
  a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |=> !(done || fault));

  a_r11_busy_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |-> !req_ready);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid);

  a_r12_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)
       && $stable(mem_req_wdata)));

  a_r12_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));

  a_r9_wb_accessed: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> mem_req_wdata[5]);

  a_r9_wb_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write && mem_req_ready) |=> done);
endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W), .ENT_W(ENT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata), .done(done), .fault(fault)
);

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [47:0] req_vaddr;
  logic [1:0]  req_acc;
  logic        req_user;
  logic [39:0] base_pfn;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic        mem_req_write;
  logic [51:0] mem_req_addr;
  logic [63:0] mem_req_wdata;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        done;
  logic [51:0] paddr;
  logic        fault;
  logic [2:0]  fault_cause;

  always #4 clk = ~clk;

  pt_walker u0 (.*);

  int checks = 0;
  int errors = 0;

  // Entry flag bits
  localparam logic [7:0] FP = 8'h01, FW = 8'h02, FU = 8'h04;
  localparam logic [7:0] FA = 8'h20, FD = 8'h40, FS = 8'h80;
  localparam logic [7:0] PWU = FP | FW | FU;
  localparam logic [39:0] BIGF = 40'h3FE00;

  function automatic logic [63:0] pte(input logic [39:0] frame,
                                      input logic [7:0] fl, input logic nx);
    return {nx, 11'b0, frame, 4'b0, fl};
  endfunction

  function automatic logic [47:0] mva(input int a, input int b, input int c,
                                      input int d, input int off);
    return {a[8:0], b[8:0], c[8:0], d[8:0], off[11:0]};
  endfunction

  typedef struct packed {
    logic [47:0] va;
    logic [1:0]  acc;
    logic        usr;
    logic        flt;
    logic [2:0]  cause;
    logic [51:0] pa;
    logic [2:0]  nrd;
    logic        wb;
    logic [1:0]  ad;
    logic [3:0]  tag;
  } vec_t;

  function automatic vec_t mv(input logic [47:0] va, input logic [1:0] acc,
      input logic usr, input logic flt, input logic [2:0] cause,
      input logic [51:0] pa, input int nrd, input logic wb,
      input logic [1:0] ad, input int tag);
    return '{va, acc, usr, flt, cause, pa, nrd[2:0], wb, ad, tag[3:0]};
  endfunction

  function automatic logic [51:0] pa4(input logic [39:0] f, input int off);
    return {f, off[11:0]};
  endfunction

  function automatic logic [51:0] pa2(input logic [39:0] f, input logic [47:0] va);
    return {f[39:9], va[20:0]};
  endfunction

  localparam int NV = 23;
  // acc: 0 read, 1 write, 2 fetch. ad = {D,A} expected in written value.
  localparam vec_t VEC [NV] = '{
    mv(mva(0,0,0,0,'h123), 0, 1, 0, 0, pa4('hABCDE,'h123), 4, 1, 2'b01, 9),  // R3 R9
    mv(mva(0,0,0,0,'hFFF), 1, 0, 0, 0, pa4('hABCDE,'hFFF), 4, 1, 2'b11, 9),  // R9 write
    mv(mva(0,0,0,1,'h010), 1, 1, 0, 0, pa4('h12345,'h010), 4, 0, 2'b00, 10), // R10
    mv(mva(0,0,0,1,0),     0, 0, 0, 0, pa4('h12345,0),     4, 0, 2'b00, 10), // R10
    mv(mva(0,0,1,'hD5,'h678), 0, 1, 0, 0, pa2(BIGF, mva(0,0,1,'hD5,'h678)), 3, 1, 2'b01, 4), // R4
    mv(mva(0,0,3,0,0),     1, 0, 0, 0, pa2(BIGF, mva(0,0,3,0,0)), 3, 0, 2'b00, 4), // R4 R10
    mv(mva(1,0,0,0,0),     0, 1, 1, 3'b001, 0, 1, 0, 2'b00, 5),  // R5 level 1
    mv(mva(0,0,2,0,0),     1, 0, 1, 3'b010, 0, 3, 0, 2'b00, 5),  // R5 level 3
    mv(mva(0,0,0,3,0),     2, 1, 1, 3'b001, 0, 4, 0, 2'b00, 8),  // R5 R8 leaf
    mv(mva(0,1,0,0,0),     1, 0, 1, 3'b110, 0, 4, 0, 2'b00, 6),  // R6 W clear upper
    mv(mva(0,1,0,0,0),     0, 1, 0, 0, pa4('hABCDE,0), 4, 1, 2'b01, 6),   // R6 read ok
    mv(mva(0,2,0,0,0),     0, 1, 1, 3'b101, 0, 4, 0, 2'b00, 7),  // R7 U clear upper
    mv(mva(0,2,0,0,0),     0, 0, 0, 0, pa4('hABCDE,0), 4, 1, 2'b01, 7),   // R7 supervisor
    mv(mva(0,3,0,0,0),     2, 0, 1, 3'b100, 0, 4, 0, 2'b00, 6),  // R6 NX upper
    mv(mva(0,3,0,0,0),     1, 0, 0, 0, pa4('hABCDE,0), 4, 1, 2'b11, 6),   // R6 NX no effect
    mv(mva(0,0,0,2,0),     1, 0, 1, 3'b110, 0, 4, 0, 2'b00, 6),  // R6 leaf W clear
    mv(mva(0,0,0,2,0),     0, 0, 0, 0, pa4('h22222,0), 4, 1, 2'b01, 9),   // R9
    mv(mva(0,0,0,4,0),     2, 1, 1, 3'b101, 0, 4, 0, 2'b00, 6),  // R6 leaf NX
    mv(mva(0,0,0,5,0),     0, 1, 1, 3'b101, 0, 4, 0, 2'b00, 7),  // R7 leaf U clear
    mv(mva(0,0,0,0,0),     2, 1, 0, 0, pa4('hABCDE,0), 4, 1, 2'b01, 9),   // R9 fetch
    mv(mva(0,0,0,1,0),     2, 0, 0, 0, pa4('h12345,0), 4, 0, 2'b00, 10),  // R10
    mv(mva(0,0,0,6,0),     0, 1, 0, 0, pa4('h66666,0), 4, 0, 2'b00, 10),  // R10 A set
    mv(mva(0,0,0,6,0),     1, 1, 0, 0, pa4('h66666,0), 4, 1, 2'b11, 9)    // R9 D clear
  };

  // Memory model: slot = {frame[3:0], index[3:0]}
  logic [63:0] mem [256];
  int          rd_cnt, wr_cnt;
  logic [63:0] last_wd;
  logic [51:0] rlog [4];
  logic        stall;

  function automatic int slot(input logic [51:0] a);
    return int'({a[15:12], a[6:3]});
  endfunction

  task automatic put(input int frame, input int idx, input logic [63:0] v);
    mem[frame*16 + idx] = v;
  endtask

  task automatic init_mem();
    for (int i = 0; i < 256; i++) mem[i] = '0;
    put(1, 0, pte(2, PWU, 0));
    put(2, 0, pte(3, PWU, 0));
    put(2, 1, pte(4, FP | FU, 0));
    put(2, 2, pte(5, FP | FW, 0));
    put(2, 3, pte(6, PWU, 1));
    put(3, 0, pte(7, PWU, 0));
    put(3, 1, pte(BIGF, PWU | FS, 0));
    put(3, 3, pte(BIGF, PWU | FS | FA | FD, 0));
    put(4, 0, pte(7, PWU, 0));
    put(5, 0, pte(7, PWU, 0));
    put(6, 0, pte(7, PWU, 0));
    put(7, 0, pte('hABCDE, PWU, 0));
    put(7, 1, pte('h12345, PWU | FA | FD, 0));
    put(7, 2, pte('h22222, FP | FU, 0));
    put(7, 4, pte('h44444, PWU, 1));
    put(7, 5, pte('h55555, FP | FW, 0));
    put(7, 6, pte('h66666, PWU | FA, 0));
    rd_cnt = 0;
    wr_cnt = 0;
    last_wd = '0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rsp_valid <= 1'b0;
      mem_req_ready <= 1'b1;
    end else begin
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_write) begin
          mem[slot(mem_req_addr)] = mem_req_wdata;
          last_wd = mem_req_wdata;
          wr_cnt++;
        end else begin
          mem_rsp_data  <= mem[slot(mem_req_addr)];
          mem_rsp_valid <= 1'b1;
          if (rd_cnt < 4) rlog[rd_cnt] = mem_req_addr;
          rd_cnt++;
        end
      end
      mem_req_ready <= stall ? ~mem_req_ready : 1'b1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v, input int n);
    int waited;
    string t;
    t = $sformatf("R%0d vec%0d", v.tag, n);
    init_mem();
    @(negedge clk);
    req_vaddr = v.va;
    req_acc   = v.acc;
    req_user  = v.usr;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    waited = 0;
    while (!(done || fault) && waited < 300) begin
      @(negedge clk);
      waited++;
    end
    chk(waited < 300, {t, " timeout"}, 64'(waited), 64'd300);
    chk(fault == v.flt && done == !v.flt, {t, " outcome"},
        {62'b0, done, fault}, {62'b0, !v.flt, v.flt});
    chk(req_ready == 1'b0, {"R11 busy ", t}, 64'(req_ready), 64'd0);
    if (v.flt) chk(fault_cause == v.cause, {"R8 cause ", t},
                   64'(fault_cause), 64'(v.cause));
    else       chk(paddr == v.pa, {t, " paddr"}, 64'(paddr), 64'(v.pa));
    chk(rd_cnt == int'(v.nrd), {t, " reads"}, 64'(rd_cnt), 64'(v.nrd));
    chk(wr_cnt == int'(v.wb), {t, " writebacks"}, 64'(wr_cnt), 64'(v.wb));
    if (v.wb) chk(last_wd[6:5] == v.ad, {"R9 AD bits ", t},
                  64'(last_wd[6:5]), 64'(v.ad));
    @(negedge clk);
    chk(!done && !fault && req_ready, {"R11 pulse ", t},
        {61'b0, done, fault, req_ready}, 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_vaddr = '0;
    req_acc = '0;
    req_user = 1'b0;
    base_pfn = 40'd1;
    stall = 1'b0;
    mem_req_ready = 1'b1;
    mem_rsp_valid = 1'b0;
    mem_rsp_data = '0;
    init_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready && !mem_req_valid && !done && !fault, "R1 reset state",
        {60'b0, req_ready, mem_req_valid, done, fault}, 64'h8);

    // Vector table, ready always then stalling memory (R12)
    for (int pass = 0; pass < 2; pass++) begin
      stall = (pass == 1);
      for (int i = 0; i < NV; i++) apply(VEC[i], i + pass*NV);
    end
    stall = 1'b0;

    // R2 entry addresses of a 2 MB walk
    apply(VEC[4], 99);
    chk(rlog[0] == 52'h0_1000, "R2 root read addr", 64'(rlog[0]), 64'h1000);
    chk(rlog[1] == 52'h0_2000, "R2 level2 read addr", 64'(rlog[1]), 64'h2000);
    chk(rlog[2] == 52'h0_3008, "R2 level3 read addr", 64'(rlog[2]), 64'h3008);
    apply(VEC[18], 100);
    chk(rlog[3] == 52'h0_7028, "R2 leaf read addr", 64'(rlog[3]), 64'h7028);

    // R1 reset in the middle of a walk
    stall = 1'b1;
    init_mem();
    @(negedge clk);
    req_vaddr = VEC[0].va;
    req_acc = 2'd0;
    req_user = 1'b0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(req_ready && !mem_req_valid && !done && !fault, "R1 reset mid-walk",
        {60'b0, req_ready, mem_req_valid, done, fault}, 64'h8);
    rst_n = 1'b1;
    stall = 1'b0;
    @(negedge clk);
    apply(VEC[1], 101);

    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end
endmodule